// File: doc/BRIEF.md
# Fixed-Page Descending Stack Unit

This block owns the stack pointer of an 8-bit processor whose stack occupies one fixed 256-byte page of a 16-bit address space. Each cycle it turns a request code into at most one stack memory access. It drives the address, the write data and the write or read strobe, and it returns the bytes it pulls. The memory array itself sits outside the block. Its read data is expected in the same cycle as the address.

Single requests push a byte, pull a byte, copy the X register into the pointer, or set the pointer to its start value. Compound requests cover subroutine calls, subroutine returns, interrupt entry and interrupt return. These run over two or three consecutive cycles and raise `busy` while they run. Interrupt entry stores a copy of the status byte whose break bit tells a software break apart from a hardware interrupt. The status value supplied at the port is not changed.

Top module: `stack_unit`

## Requirements
- R1: Every stack access drives mem_addr[15:8] = 0x01, so all accesses fall in 0x0100 to 0x01FF.
- R2: A push writes its byte at address 0x0100 + SP and then decrements SP by one.
- R3: A pull increments SP first and then reads 0x0100 + SP (the new value). For a plain pull (req_op 2) and for the status pull of an interrupt return, the byte appears on pull_data with pull_valid high in the following cycle.
- R4: After reset, SP is 0xFF. Request 4 sets SP to 0xFF, and request 3 loads SP from x_val. Neither request accesses memory.
- R5: SP wraps modulo 256 in both directions and raises no error.
- R6: A subroutine call (req_op 5) pushes pc_in[15:8] and then pc_in[7:0] in two consecutive cycles, so the low byte ends up at the lower address.
- R7: A subroutine return (req_op 6) pulls the low byte and then the high byte. In the cycle after the second pull, pc_out holds {high, low} and pc_valid is high.
- R8: Interrupt entry (req_op 7) pushes the PC high byte, then the PC low byte, then status_in with bit 4 replaced by is_break. The break bit is 1 for a software break and 0 for a hardware interrupt.
- R9: Interrupt return (req_op 8) pulls the status byte (reported on pull_data), then the PC low byte, then the PC high byte (reported on pc_out).
- R10: Any request presented while busy is high is ignored.
- R11: The block never writes and reads in the same cycle.

Request codes on req_op are: 0 none, 1 push, 2 pull, 3 load from X, 4 initialise, 5 call, 6 return, 7 interrupt entry, 8 interrupt return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 4 | Request code (see requirements) |
| push_data | input | 8 | Byte for a plain push |
| x_val | input | 8 | X register value for the load request |
| pc_in | input | 16 | Return address for call or interrupt entry |
| status_in | input | 8 | Status byte for interrupt entry |
| is_break | input | 1 | Break bit value for the stacked status |
| mem_rdata | input | 8 | Read data for mem_addr, same cycle |
| busy | output | 1 | A compound request is in progress |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pull_valid | output | 1 | pull_data holds a pulled byte |
| pull_data | output | 8 | Pulled byte |
| pc_out | output | 16 | Restored return address |
| pc_valid | output | 1 | pc_out is valid this cycle |
| sp_out | output | 8 | Current stack pointer |

## Verification
The bench drives SP across the 0x00/0xFF boundary in both directions. A design that forgot the modulo behaviour, or that carried into the page byte, would write outside 0x01xx or return the wrong bytes. Pushes and pulls are mixed with calls and interrupts, and every address and byte order is checked. A design that pulled before incrementing, or that stacked the PC bytes in the wrong order, would return a swapped or off-by-one address. Interrupt entry is run with both break values, using status values where bit 4 would otherwise show the opposite value. A request arriving in the middle of a call must leave no extra write and no SP change behind.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_PUSH  = 4'd1,
        OP_PULL  = 4'd2,
        OP_LOADX = 4'd3,
        OP_INIT  = 4'd4,
        OP_CALL  = 4'd5,
        OP_RET   = 4'd6,
        OP_IRQ   = 4'd7,
        OP_RTI   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        UK_NONE,
        UK_PUSH,
        UK_PULL,
        UK_LOAD
    } ukind_e;

    typedef enum logic [1:0] {
        TG_BYTE,
        TG_PCL,
        TG_PCH
    } tag_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CALL_LO,
        SQ_IRQ_LO,
        SQ_IRQ_ST,
        SQ_RET_HI,
        SQ_RTI_LO,
        SQ_RTI_HI
    } seq_e;

    typedef struct packed {
        ukind_e             kind;
        logic [BYTE_W-1:0]  val;
        tag_e               tag;
    } uop_t;

    function automatic logic [BYTE_W-1:0] stacked_status(
        input logic [BYTE_W-1:0] st,
        input logic              brk,
        input int                pos
    );
        logic [BYTE_W-1:0] r;
        r      = st;
        r[pos] = brk;
        return r;
    endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] INIT_SP = 8'hFF,
    parameter int                BRK_BIT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  op_e                 op,
    input  logic [BYTE_W-1:0]   push_data,
    input  logic [BYTE_W-1:0]   x_val,
    input  logic [2*BYTE_W-1:0] pc_in,
    input  logic [BYTE_W-1:0]   status_in,
    input  logic                is_break,
    output uop_t                uop,
    output logic                busy
);
    seq_e                state, nxt;
    logic [2*BYTE_W-1:0] pc_q;
    logic [BYTE_W-1:0]   st_q;
    logic                brk_q;

    always_comb begin
        uop = '{kind: UK_NONE, val: '0, tag: TG_BYTE};
        nxt = state;
        case (state)
            SQ_IDLE: begin
                case (op)
                    OP_PUSH:  uop = '{kind: UK_PUSH, val: push_data, tag: TG_BYTE};
                    OP_PULL:  uop = '{kind: UK_PULL, val: '0, tag: TG_BYTE};
                    OP_LOADX: uop = '{kind: UK_LOAD, val: x_val, tag: TG_BYTE};
                    OP_INIT:  uop = '{kind: UK_LOAD, val: INIT_SP, tag: TG_BYTE};
                    OP_CALL: begin
                        uop = '{kind: UK_PUSH, val: pc_in[2*BYTE_W-1:BYTE_W], tag: TG_BYTE};
                        nxt = SQ_CALL_LO;
                    end
                    OP_IRQ: begin
                        uop = '{kind: UK_PUSH, val: pc_in[2*BYTE_W-1:BYTE_W], tag: TG_BYTE};
                        nxt = SQ_IRQ_LO;
                    end
                    OP_RET: begin
                        uop = '{kind: UK_PULL, val: '0, tag: TG_PCL};
                        nxt = SQ_RET_HI;
                    end
                    OP_RTI: begin
                        uop = '{kind: UK_PULL, val: '0, tag: TG_BYTE};
                        nxt = SQ_RTI_LO;
                    end
                    default: ;
                endcase
            end
            SQ_CALL_LO: begin
                uop = '{kind: UK_PUSH, val: pc_q[BYTE_W-1:0], tag: TG_BYTE};
                nxt = SQ_IDLE;
            end
            SQ_IRQ_LO: begin
                uop = '{kind: UK_PUSH, val: pc_q[BYTE_W-1:0], tag: TG_BYTE};
                nxt = SQ_IRQ_ST;
            end
            SQ_IRQ_ST: begin
                uop = '{kind: UK_PUSH, val: stacked_status(st_q, brk_q, BRK_BIT), tag: TG_BYTE};
                nxt = SQ_IDLE;
            end
            SQ_RET_HI, SQ_RTI_HI: begin
                uop = '{kind: UK_PULL, val: '0, tag: TG_PCH};
                nxt = SQ_IDLE;
            end
            SQ_RTI_LO: begin
                uop = '{kind: UK_PULL, val: '0, tag: TG_PCL};
                nxt = SQ_RTI_HI;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            pc_q  <= '0;
            st_q  <= '0;
            brk_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == SQ_IDLE) begin
                pc_q  <= pc_in;
                st_q  <= status_in;
                brk_q <= is_break;
            end
        end
    end

    assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAGE_HI = 8'h01,
    parameter logic [BYTE_W-1:0] INIT_SP = 8'hFF
) (
    input  logic                clk,
    input  logic                rst,
    input  ukind_e              kind,
    input  logic [BYTE_W-1:0]   load_val,
    output logic [BYTE_W-1:0]   sp,
    output logic [2*BYTE_W-1:0] addr
);
    logic [BYTE_W-1:0] sp_up;

    assign sp_up = sp + 1'b1;
    assign addr  = {PAGE_HI, (kind == UK_PULL) ? sp_up : sp};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= INIT_SP;
        end else begin
            case (kind)
                UK_PUSH: sp <= sp - 1'b1;
                UK_PULL: sp <= sp_up;
                UK_LOAD: sp <= load_val;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stk_ret.sv
module stk_ret
    import stk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd,
    input  tag_e                tag,
    input  logic [BYTE_W-1:0]   rdata,
    output logic                pull_valid,
    output logic [BYTE_W-1:0]   pull_data,
    output logic [2*BYTE_W-1:0] pc_out,
    output logic                pc_valid
);
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_valid <= 1'b0;
            pull_data  <= '0;
            pc_out     <= '0;
            pc_valid   <= 1'b0;
            lo_q       <= '0;
        end else begin
            pull_valid <= rd && (tag == TG_BYTE);
            pc_valid   <= rd && (tag == TG_PCH);
            if (rd) begin
                case (tag)
                    TG_BYTE: pull_data <= rdata;
                    TG_PCL:  lo_q      <= rdata;
                    TG_PCH:  pc_out    <= {rdata, lo_q};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stk_pkg::*;
#(
    parameter logic [7:0] PAGE_HI = 8'h01,
    parameter logic [7:0] INIT_SP = 8'hFF,
    parameter int         BRK_BIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  req_op,
    input  logic [7:0]  push_data,
    input  logic [7:0]  x_val,
    input  logic [15:0] pc_in,
    input  logic [7:0]  status_in,
    input  logic        is_break,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    output logic        pull_valid,
    output logic [7:0]  pull_data,
    output logic [15:0] pc_out,
    output logic        pc_valid,
    output logic [7:0]  sp_out
);
    uop_t uop;

    stk_seq #(.INIT_SP(INIT_SP), .BRK_BIT(BRK_BIT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op        (op_e'(req_op)),
        .push_data (push_data),
        .x_val     (x_val),
        .pc_in     (pc_in),
        .status_in (status_in),
        .is_break  (is_break),
        .uop       (uop),
        .busy      (busy)
    );

    stk_ptr #(.PAGE_HI(PAGE_HI), .INIT_SP(INIT_SP)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .kind     (uop.kind),
        .load_val (uop.val),
        .sp       (sp_out),
        .addr     (mem_addr)
    );

    assign mem_we    = (uop.kind == UK_PUSH);
    assign mem_re    = (uop.kind == UK_PULL);
    assign mem_wdata = uop.val;

    stk_ret u_ret (
        .clk        (clk),
        .rst        (rst),
        .rd         (mem_re),
        .tag        (uop.tag),
        .rdata      (mem_rdata),
        .pull_valid (pull_valid),
        .pull_data  (pull_data),
        .pc_out     (pc_out),
        .pc_valid   (pc_valid)
    );
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter logic [7:0] PAGE_HI = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic [7:0]  sp_out,
    input logic        pull_valid,
    input logic        pc_valid
);
    // R1
    page_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (mem_addr[15:8] == PAGE_HI));

    // R2
    push_at_sp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[7:0] == sp_out));

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == $past(sp_out) - 8'd1));

    // R3
    pull_above_sp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr[7:0] == sp_out + 8'd1));

    // R3
    pull_inc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (sp_out == $past(sp_out) + 8'd1));

    // R3
    pull_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        pull_valid |-> $past(mem_re));

    // R7
    pc_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> $past(mem_re));

    // R11
    no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
endmodule

bind stack_unit stk_chk #(.PAGE_HI(PAGE_HI)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .sp_out     (sp_out),
    .pull_valid (pull_valid),
    .pc_valid   (pc_valid)
);

// File: tb/tb_stack_unit.sv
module tb_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req_op = 4'd0;
    logic [7:0]  push_data = 8'h00;
    logic [7:0]  x_val = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  status_in = 8'h00;
    logic        is_break = 1'b0;
    logic [7:0]  mem_rdata;
    logic        busy, mem_we, mem_re, pull_valid, pc_valid;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, pull_data, sp_out;

    stack_unit dut (
        .clk(clk), .rst(rst), .req_op(req_op), .push_data(push_data),
        .x_val(x_val), .pc_in(pc_in), .status_in(status_in),
        .is_break(is_break), .mem_rdata(mem_rdata), .busy(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .pull_valid(pull_valid), .pull_data(pull_data),
        .pc_out(pc_out), .pc_valid(pc_valid), .sp_out(sp_out)
    );

    always #5 clk = ~clk;

    // stack page memory
    logic [7:0] page_mem [0:255];
    initial for (int i = 0; i < 256; i++) page_mem[i] = 8'h00;
    assign mem_rdata = page_mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) page_mem[mem_addr[7:0]] <= mem_wdata;

    int compared = 0;
    int mismatched = 0;

    // reference model
    logic [7:0]  esp = 8'hFF;
    logic [7:0]  mdl [0:255];
    logic [23:0] exp_w [$];
    logic [15:0] exp_r [$];
    logic [7:0]  exp_pull [$];
    logic [15:0] exp_pc [$];

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic m_push(input logic [7:0] b);
        exp_w.push_back({8'h01, esp, b});
        mdl[esp] = b;
        esp = esp - 8'd1;
    endtask

    task automatic m_pull(output logic [7:0] b);
        esp = esp + 8'd1;
        exp_r.push_back({8'h01, esp});
        b = mdl[esp];
    endtask

    task automatic issue(input logic [3:0] op);
        @(posedge clk); #1;
        req_op = op;
        @(posedge clk); #1;
        req_op = 4'd0;
        while (busy) begin @(posedge clk); #1; end
    endtask

    task automatic do_push(input logic [7:0] b);
        m_push(b); push_data = b; issue(4'd1);
    endtask

    task automatic do_pull();
        logic [7:0] b;
        m_pull(b); exp_pull.push_back(b); issue(4'd2);
    endtask

    task automatic do_call(input logic [15:0] pc);
        m_push(pc[15:8]); m_push(pc[7:0]); pc_in = pc; issue(4'd5);
    endtask

    task automatic do_ret();
        logic [7:0] lo, hi;
        m_pull(lo); m_pull(hi); exp_pc.push_back({hi, lo}); issue(4'd6);
    endtask

    task automatic do_irq(input logic [15:0] pc, input logic [7:0] st, input logic brk);
        m_push(pc[15:8]); m_push(pc[7:0]);
        m_push({st[7:5], brk, st[3:0]});
        pc_in = pc; status_in = st; is_break = brk;
        issue(4'd7);
    endtask

    task automatic do_rti();
        logic [7:0] s, lo, hi;
        m_pull(s); exp_pull.push_back(s);
        m_pull(lo); m_pull(hi); exp_pc.push_back({hi, lo});
        issue(4'd8);
    endtask

    task automatic chk_sp(input string req);
        chk(sp_out == esp, req, {24'h0, sp_out}, {24'h0, esp});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (exp_w.size() == 0) chk(1'b0, "R10 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
                else begin
                    logic [23:0] e;
                    e = exp_w.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R1/R2 write addr+data", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
                end
            end
            if (mem_re) begin
                if (exp_r.size() == 0) chk(1'b0, "R10 unexpected read", {16'h0, mem_addr}, 32'h0);
                else begin
                    logic [15:0] e;
                    e = exp_r.pop_front();
                    chk(mem_addr == e, "R1/R3 read addr", {16'h0, mem_addr}, {16'h0, e});
                end
            end
            if (pull_valid) begin
                if (exp_pull.size() == 0) chk(1'b0, "R3 unexpected pull_valid", {24'h0, pull_data}, 32'h0);
                else begin
                    logic [7:0] e;
                    e = exp_pull.pop_front();
                    chk(pull_data == e, "R3/R9 pulled byte", {24'h0, pull_data}, {24'h0, e});
                end
            end
            if (pc_valid) begin
                if (exp_pc.size() == 0) chk(1'b0, "R7 unexpected pc_valid", {16'h0, pc_out}, 32'h0);
                else begin
                    logic [15:0] e;
                    e = exp_pc.pop_front();
                    chk(pc_out == e, "R7/R9 restored pc", {16'h0, pc_out}, {16'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R4 reset state
        chk(sp_out == 8'hFF, "R4 reset sp", {24'h0, sp_out}, 32'hFF);
        chk(!busy, "R4 reset busy", {31'h0, busy}, 32'h0);
        chk(!pull_valid && !pc_valid, "R4 reset valids", {30'h0, pull_valid, pc_valid}, 32'h0);
        chk(!mem_we && !mem_re, "R11 idle strobes", {30'h0, mem_we, mem_re}, 32'h0);

        // R4 initialise, R2 pushes, R3 LIFO pulls
        esp = 8'hFF; issue(4'd4); chk_sp("R4 init");
        do_push(8'hA1); do_push(8'hB2); do_push(8'hC3);
        chk_sp("R2 sp after pushes");
        do_pull(); do_pull(); do_pull();
        chk_sp("R3 sp after pulls");

        // R4 load from X, R5 wrap downward then upward
        x_val = 8'h02; esp = 8'h02; issue(4'd3); chk_sp("R4 load from x");
        do_push(8'h11); do_push(8'h22); do_push(8'h33); do_push(8'h44);
        chk_sp("R5 wrap below zero");
        do_pull(); do_pull(); do_pull(); do_pull();
        chk_sp("R5 wrap above ff");

        // R6 call, R7 return
        esp = 8'hFF; issue(4'd4);
        do_call(16'h1234); chk_sp("R6 sp after call");
        do_ret(); chk_sp("R7 sp after return");

        // R8 interrupt entry with break set, R9 return
        do_irq(16'hBEEF, 8'h00, 1'b1); chk_sp("R8 sp after brk entry");
        do_rti(); chk_sp("R9 sp after rti");
        // R8 hardware interrupt clears bit 4
        do_irq(16'h0102, 8'hFF, 1'b0);
        do_rti(); chk_sp("R9 sp after second rti");

        // nested call with data, across wrap
        x_val = 8'h01; esp = 8'h01; issue(4'd3);
        do_call(16'h1111); do_push(8'h5A); do_pull(); do_ret();
        chk_sp("R5 nested call across wrap");

        // R10 request during call is ignored
        esp = 8'hFF; issue(4'd4);
        m_push(8'hAB); m_push(8'hCD);
        @(posedge clk); #1;
        pc_in = 16'hABCD; req_op = 4'd5;
        @(posedge clk); #1;
        push_data = 8'h77; req_op = 4'd1;
        @(posedge clk); #1;
        req_op = 4'd0;
        while (busy) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        chk_sp("R10 sp after ignored push");
        do_ret(); chk_sp("R10 return after ignored push");

        repeat (3) @(posedge clk);
        chk(exp_w.size() == 0, "R2 writes outstanding", exp_w.size(), 32'h0);
        chk(exp_r.size() == 0, "R3 reads outstanding", exp_r.size(), 32'h0);
        chk(exp_pull.size() == 0, "R3 pulls outstanding", exp_pull.size(), 32'h0);
        chk(exp_pc.size() == 0, "R7 pc outstanding", exp_pc.size(), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule